// File: doc/BRIEF.md
# Packed SIMD Compare and Average Execution Unit

This unit executes one minor-opcode group of a 32-bit media extension in a single clock. Each cycle in which the valid strobe is high it decodes the 32-bit instruction word, reads two operands from its own file of fifteen 32-bit media registers (index 0 is a constant zero), and computes one of six results: a whole-word signed less-than test, a two-lane signed 16-bit less-than test, a two-lane signed 16-bit average with or without round-up, or a four-lane unsigned 8-bit average with or without round-up.

The result is written back into the register file at the clock edge that accepts the instruction and is also shown on a registered write port for one cycle, so that a dependent instruction may follow in the very next cycle. Undefined minor opcodes raise a one-cycle reserved-instruction flag. Words with a non-zero padding field, or that belong to another major opcode, have no effect at all. Other execution units share the register file through a writeback input.

Top module: `mvec_cmpavg_unit`

## Requirements
- R1: The unit acts only on a valid word whose bits 5:0 equal 0x06; any other word changes no register and raises neither wr_en nor rsvd_flag.
- R2: The operation is chosen by bits 20:18 (0 word compare, 1 half compare, 2 half average, 3 half average rounded, 4 byte average, 5 byte average rounded); codes 6 and 7 raise rsvd_flag for one cycle and write no register, whatever the padding bits hold.
- R3: For codes 0 to 5, a non-zero value in bits 25:21 makes the word a silent no-op: no write and no flag.
- R4: The destination index is bits 9:6, the first source bits 13:10, the second source bits 17:14; source index 0 reads as zero and a result aimed at index 0 is dropped (wr_en stays low).
- R5: Code 0 writes 1 when the first source is below the second as signed 32-bit numbers, else 0.
- R6: Code 1 compares each signed 16-bit half on its own and puts the 0/1 outcome in bit 0 of that half (bits 16 and 0); all other bits are 0.
- R7: Codes 2 and 3 sign-extend each 16-bit half of both sources to 17 bits, add them, add 1 for code 3, and store bits 16:1 of the sum in that half.
- R8: Codes 4 and 5 zero-extend each byte to 9 bits, add the pair, add 1 for code 5, and store bits 8:1 of the sum in that byte.
- R9: When both sources name the same register, codes 0 and 1 return 0 and codes 2 to 5 return that register's value.
- R10: wr_en, wr_idx, wr_data and rsvd_flag are registered: they reflect the word accepted at the previous clock edge for exactly one cycle, and the written register is visible to the very next instruction.
- R11: The writeback input (ext_we, ext_idx, ext_data) loads a register at the clock edge; if the unit writes the same index in the same cycle the unit's result is kept.
- R12: Reset (rst_n low, asynchronous) clears every register and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Instruction word |
| ext_we | input | 1 | Writeback from another unit |
| ext_idx | input | 4 | Writeback register index |
| ext_data | input | 32 | Writeback data |
| wr_en | output | 1 | A register was written by this unit |
| wr_idx | output | 4 | Index of the written register |
| wr_data | output | 32 | Value written |
| rsvd_flag | output | 1 | Undefined minor opcode was seen |

## Verification
A fault in the lane arithmetic or the decode shows on wr_data or the flags in the cycle right after the strobe, so every vector is checked there. A corrupted register only surfaces when it is next read, so the bench reads registers back with a same-source average, which must return the stored value untouched; this brings a bad file state to the write port one instruction later. Back-to-back and collision cases expose a write that lands a cycle late or loses its priority.

// File: rtl/mvec_pkg.sv
package mvec_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 16;
  localparam int IDX_W  = $clog2(NREG);

  // field positions decoded by the unit
  localparam int MAJ_LSB = 0;
  localparam int MAJ_W   = 6;
  localparam int DST_LSB = 6;
  localparam int SB_LSB  = 10;
  localparam int SC_LSB  = 14;
  localparam int MIN_LSB = 18;
  localparam int MIN_W   = 3;
  localparam int PAD_LSB = 21;
  localparam int PAD_W   = 5;

  localparam logic [MAJ_W-1:0] MAJ_POOL = 6'h06;

  localparam logic [MIN_W-1:0] OP_SLT_W  = 3'd0;
  localparam logic [MIN_W-1:0] OP_SLT_H  = 3'd1;
  localparam logic [MIN_W-1:0] OP_AVG_H  = 3'd2;
  localparam logic [MIN_W-1:0] OP_AVGR_H = 3'd3;
  localparam logic [MIN_W-1:0] OP_AVG_B  = 3'd4;
  localparam logic [MIN_W-1:0] OP_AVGR_B = 3'd5;
  localparam logic [MIN_W-1:0] OP_LAST   = OP_AVGR_B;
endpackage

// File: rtl/mvec_decode.sv
module mvec_decode
  import mvec_pkg::*;
(
  input  logic             insn_valid,
  input  logic [XLEN-1:0]  insn_word,
  output logic             write_go,
  output logic             reserved_go,
  output logic [MIN_W-1:0] op,
  output logic [IDX_W-1:0] dst,
  output logic [IDX_W-1:0] src_b,
  output logic [IDX_W-1:0] src_c
);
  logic in_pool;
  logic pad_clean;
  logic op_defined;
  logic unused_hi;

  assign op        = insn_word[MIN_LSB +: MIN_W];
  assign dst       = insn_word[DST_LSB +: IDX_W];
  assign src_b     = insn_word[SB_LSB +: IDX_W];
  assign src_c     = insn_word[SC_LSB +: IDX_W];
  assign unused_hi = ^insn_word[XLEN-1:PAD_LSB+PAD_W];

  assign in_pool    = insn_valid && (insn_word[MAJ_LSB +: MAJ_W] == MAJ_POOL);
  assign pad_clean  = (insn_word[PAD_LSB +: PAD_W] == '0);
  assign op_defined = (op <= OP_LAST);

  // undefined codes are flagged before padding is looked at
  assign reserved_go = in_pool && !op_defined;
  assign write_go    = in_pool && op_defined && pad_clean && (dst != '0);
endmodule

// File: rtl/mvec_regfile.sv
module mvec_regfile #(
  parameter int W    = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_b_idx,
  input  logic [IW-1:0] rd_c_idx,
  output logic [W-1:0]  rd_b_data,
  output logic [W-1:0]  rd_c_data,
  input  logic          unit_we,
  input  logic [IW-1:0] unit_idx,
  input  logic [W-1:0]  unit_data,
  input  logic          ext_we,
  input  logic [IW-1:0] ext_idx,
  input  logic [W-1:0]  ext_data
);
  logic [W-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (unit_we && unit_idx == IW'(i))
          mem[i] <= unit_data;
        else if (ext_we && ext_idx == IW'(i))
          mem[i] <= ext_data;
      end
    end
  end

  assign rd_b_data = (rd_b_idx == '0) ? '0 : mem[rd_b_idx];
  assign rd_c_data = (rd_c_idx == '0) ? '0 : mem[rd_c_idx];
endmodule

// File: rtl/mvec_lane_alu.sv
module mvec_lane_alu
  import mvec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [MIN_W-1:0] op,
  input  logic [W-1:0]     src_b,
  input  logic [W-1:0]     src_c,
  output logic [W-1:0]     result
);
  localparam int HW = 16;
  localparam int BW = 8;
  localparam int NH = W / HW;
  localparam int NB = W / BW;

  // signed half average: 17-bit sum, keep the upper 16 bits
  function automatic logic [HW-1:0] avg_half(input logic [HW-1:0] x,
                                             input logic [HW-1:0] y,
                                             input logic up);
    logic [HW:0] s;
    s = {x[HW-1], x} + {y[HW-1], y} + {{HW{1'b0}}, up};
    return s[HW:1];
  endfunction

  // unsigned byte average: 9-bit sum, keep the upper 8 bits
  function automatic logic [BW-1:0] avg_byte(input logic [BW-1:0] x,
                                             input logic [BW-1:0] y,
                                             input logic up);
    logic [BW:0] s;
    s = {1'b0, x} + {1'b0, y} + {{BW{1'b0}}, up};
    return s[BW:1];
  endfunction

  function automatic logic lt_signed_half(input logic [HW-1:0] x,
                                          input logic [HW-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  logic         round_up;
  logic [W-1:0] slt_w, slt_h, avg_h, avg_b;

  assign round_up = (op == OP_AVGR_H) || (op == OP_AVGR_B);
  assign slt_w    = {{(W-1){1'b0}}, ($signed(src_b) < $signed(src_c))};

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign slt_h[h*HW +: HW] = {{(HW-1){1'b0}},
                                lt_signed_half(src_b[h*HW +: HW], src_c[h*HW +: HW])};
    assign avg_h[h*HW +: HW] = avg_half(src_b[h*HW +: HW], src_c[h*HW +: HW], round_up);
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign avg_b[b*BW +: BW] = avg_byte(src_b[b*BW +: BW], src_c[b*BW +: BW], round_up);
  end

  always_comb begin
    case (op)
      OP_SLT_W:             result = slt_w;
      OP_SLT_H:             result = slt_h;
      OP_AVG_H, OP_AVGR_H:  result = avg_h;
      OP_AVG_B, OP_AVGR_B:  result = avg_b;
      default:              result = '0;
    endcase
  end
endmodule

// File: rtl/mvec_cmpavg_unit.sv
module mvec_cmpavg_unit
  import mvec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_valid,
  input  logic [XLEN-1:0]  insn_word,
  input  logic             ext_we,
  input  logic [IDX_W-1:0] ext_idx,
  input  logic [XLEN-1:0]  ext_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic             rsvd_flag
);
  // named internal events
  logic             dec_write_go;
  logic             dec_reserved;
  logic [MIN_W-1:0] dec_op;
  logic [IDX_W-1:0] dec_dst, dec_sb, dec_sc;
  logic [XLEN-1:0]  opnd_b, opnd_c;
  logic [XLEN-1:0]  alu_result;

  mvec_decode u_dec (
    .insn_valid  (insn_valid),
    .insn_word   (insn_word),
    .write_go    (dec_write_go),
    .reserved_go (dec_reserved),
    .op          (dec_op),
    .dst         (dec_dst),
    .src_b       (dec_sb),
    .src_c       (dec_sc)
  );

  mvec_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_b_idx  (dec_sb),
    .rd_c_idx  (dec_sc),
    .rd_b_data (opnd_b),
    .rd_c_data (opnd_c),
    .unit_we   (dec_write_go),
    .unit_idx  (dec_dst),
    .unit_data (alu_result),
    .ext_we    (ext_we),
    .ext_idx   (ext_idx),
    .ext_data  (ext_data)
  );

  mvec_lane_alu #(.W(XLEN)) u_alu (
    .op     (dec_op),
    .src_b  (opnd_b),
    .src_c  (opnd_c),
    .result (alu_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      rsvd_flag <= 1'b0;
    end else begin
      wr_en     <= dec_write_go;
      wr_idx    <= dec_write_go ? dec_dst : '0;
      wr_data   <= dec_write_go ? alu_result : '0;
      rsvd_flag <= dec_reserved;
    end
  end
endmodule

// File: rtl/mvec_cmpavg_checker.sv
module mvec_cmpavg_checker
  import mvec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             insn_valid,
  input logic [XLEN-1:0]  insn_word,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [XLEN-1:0]  wr_data,
  input logic             rsvd_flag
);
  logic             pool_hit;
  logic [MIN_W-1:0] minor;
  logic             pad_dirty;

  assign pool_hit  = insn_valid && (insn_word[MAJ_LSB +: MAJ_W] == MAJ_POOL);
  assign minor     = insn_word[MIN_LSB +: MIN_W];
  assign pad_dirty = (insn_word[PAD_LSB +: PAD_W] != '0);

  p_foreign_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !pool_hit) |=> (!wr_en && !rsvd_flag));

  p_reserved_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_hit && minor > OP_LAST) |=> (rsvd_flag && !wr_en));

  p_pad_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_hit && minor <= OP_LAST && pad_dirty) |=> (!wr_en && !rsvd_flag));

  p_no_zero_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));

  p_word_slt_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(minor) == OP_SLT_W) |-> (wr_data[XLEN-1:1] == '0));

  p_half_slt_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(minor) == OP_SLT_H) |-> ((wr_data & 32'hFFFE_FFFE) == '0));

  p_write_follows_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rsvd_flag) |-> $past(insn_valid));

  p_flag_write_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rsvd_flag));
endmodule

bind mvec_cmpavg_unit mvec_cmpavg_checker u_chk (.*);

// File: tb/mvec_cmpavg_unit_test.sv
module mvec_cmpavg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic        ext_we = 1'b0;
  logic [3:0]  ext_idx = '0;
  logic [31:0] ext_data = '0;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic        rsvd_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mvec_cmpavg_unit uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .ext_we(ext_we), .ext_idx(ext_idx), .ext_data(ext_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rsvd_flag(rsvd_flag)
  );

  // {op, first source, second source, expected}
  localparam int NV = 12;
  localparam logic [98:0] VEC [NV] = '{
    {3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    {3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000},
    {3'd0, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001},
    {3'd1, 32'h8000_0005, 32'h7FFF_0004, 32'h0001_0000},
    {3'd1, 32'h0001_FFFF, 32'h0002_0000, 32'h0001_0001},
    {3'd1, 32'h8000_8000, 32'h8000_7FFF, 32'h0000_0001},
    {3'd2, 32'h7FFF_8000, 32'h7FFF_8000, 32'h7FFF_8000},
    {3'd2, 32'h0003_FFFF, 32'h0000_0000, 32'h0001_FFFF},
    {3'd3, 32'h0003_FFFF, 32'h0000_0000, 32'h0002_0000},
    {3'd3, 32'h7FFF_8000, 32'h0000_8000, 32'h4000_8000},
    {3'd4, 32'hFF01_0080, 32'hFF00_FF81, 32'hFF00_7F80},
    {3'd5, 32'hFF01_0080, 32'hFF00_FF81, 32'hFF01_8081}
  };

  function automatic logic [31:0] enc(input logic [2:0] minor, input logic [3:0] d,
                                      input logic [3:0] sb, input logic [3:0] sc,
                                      input logic [4:0] pad, input logic [5:0] major);
    return {6'b0, pad, minor, sc, sb, d, major};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic ext_load(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    ext_we = 1'b1; ext_idx = idx; ext_data = val;
    @(negedge clk);
    ext_we = 1'b0; ext_idx = '0; ext_data = '0;
  endtask

  // outputs are sampled at the negedge after the capturing edge
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w;
    @(negedge clk);
    insn_valid = 1'b0; insn_word = '0;
  endtask

  // same-source half average returns the register itself (R9)
  task automatic read_reg(input logic [3:0] idx, output logic [31:0] val);
    issue(enc(3'd2, 4'd15, idx, idx, 5'd0, 6'h06));
    val = wr_data;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk_eq("R12 wr_en after reset", {31'b0, wr_en}, 32'h0);
    chk_eq("R12 rsvd_flag after reset", {31'b0, rsvd_flag}, 32'h0);
    chk_eq("R12 wr_data after reset", wr_data, 32'h0);
    rst_n = 1'b1;
    read_reg(4'd5, rv);
    chk_eq("R12 register cleared", rv, 32'h0);

    // R5 R6 R7 R8: vector table
    for (int i = 0; i < NV; i++) begin
      ext_load(4'd1, VEC[i][95:64]);
      ext_load(4'd2, VEC[i][63:32]);
      issue(enc(VEC[i][98:96], 4'd3, 4'd1, 4'd2, 5'd0, 6'h06));
      chk_eq($sformatf("R5-8 vector %0d op %0d wr_en", i, VEC[i][98:96]), {31'b0, wr_en}, 32'h1);
      chk_eq($sformatf("R4 vector %0d wr_idx", i), {28'b0, wr_idx}, 32'h3);
      chk_eq($sformatf("R5 R6 R7 R8 vector %0d result", i), wr_data, VEC[i][31:0]);
      read_reg(4'd3, rv);
      chk_eq($sformatf("R10 vector %0d stored", i), rv, VEC[i][31:0]);
    end

    // R9: same source for all six operations
    ext_load(4'd4, 32'h80FF_7F01);
    for (int op = 0; op < 6; op++) begin
      issue(enc(3'(op), 4'd6, 4'd4, 4'd4, 5'd0, 6'h06));
      chk_eq($sformatf("R9 same source op %0d", op), wr_data,
             (op < 2) ? 32'h0 : 32'h80FF_7F01);
    end

    // R10: pulse lasts one cycle
    @(negedge clk);
    chk_eq("R10 wr_en one cycle", {31'b0, wr_en}, 32'h0);

    // R2: reserved codes, also with dirty padding
    issue(enc(3'd6, 4'd7, 4'd4, 4'd1, 5'd0, 6'h06));
    chk_eq("R2 code 6 flag", {31'b0, rsvd_flag}, 32'h1);
    chk_eq("R2 code 6 no write", {31'b0, wr_en}, 32'h0);
    issue(enc(3'd7, 4'd7, 4'd4, 4'd1, 5'd3, 6'h06));
    chk_eq("R2 code 7 flag", {31'b0, rsvd_flag}, 32'h1);
    @(negedge clk);
    chk_eq("R2 flag one cycle", {31'b0, rsvd_flag}, 32'h0);
    read_reg(4'd7, rv);
    chk_eq("R2 register untouched", rv, 32'h0);

    // R3: dirty padding is silent
    ext_load(4'd8, 32'h1234_5678);
    issue(enc(3'd4, 4'd8, 4'd4, 4'd0, 5'h10, 6'h06));
    chk_eq("R3 no write", {31'b0, wr_en}, 32'h0);
    chk_eq("R3 no flag", {31'b0, rsvd_flag}, 32'h0);
    read_reg(4'd8, rv);
    chk_eq("R3 register kept", rv, 32'h1234_5678);

    // R1: foreign major opcode
    issue(enc(3'd4, 4'd8, 4'd4, 4'd0, 5'd0, 6'h07));
    chk_eq("R1 no write", {31'b0, wr_en}, 32'h0);
    issue(enc(3'd7, 4'd8, 4'd4, 4'd0, 5'd0, 6'h26));
    chk_eq("R1 no flag", {31'b0, rsvd_flag}, 32'h0);
    read_reg(4'd8, rv);
    chk_eq("R1 register kept", rv, 32'h1234_5678);

    // R4: zero register as source and destination
    ext_load(4'd1, 32'h0000_0001);
    issue(enc(3'd0, 4'd9, 4'd0, 4'd1, 5'd0, 6'h06));
    chk_eq("R4 zero source compare", wr_data, 32'h1);
    issue(enc(3'd3, 4'd9, 4'd8, 4'd0, 5'd0, 6'h06));
    chk_eq("R4 zero source average", wr_data, 32'h091A_2B3C);
    issue(enc(3'd2, 4'd0, 4'd8, 4'd8, 5'd0, 6'h06));
    chk_eq("R4 zero destination dropped", {31'b0, wr_en}, 32'h0);
    read_reg(4'd0, rv);
    chk_eq("R4 zero reads zero", rv, 32'h0);

    // R10: back-to-back dependence
    ext_load(4'd1, 32'h0003_0003);
    ext_load(4'd2, 32'h0001_0001);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = enc(3'd3, 4'd10, 4'd1, 4'd2, 5'd0, 6'h06);
    @(negedge clk);
    chk_eq("R10 first of pair", wr_data, 32'h0002_0002);
    insn_word = enc(3'd4, 4'd11, 4'd10, 4'd0, 5'd0, 6'h06);
    @(negedge clk);
    insn_valid = 1'b0; insn_word = '0;
    chk_eq("R10 dependent second", wr_data, 32'h0001_0001);

    // R11: writeback collision, unit wins; other index lands
    ext_load(4'd1, 32'hFFFF_FFFF);
    ext_load(4'd2, 32'h0000_0000);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = enc(3'd0, 4'd12, 4'd1, 4'd2, 5'd0, 6'h06);
    ext_we = 1'b1; ext_idx = 4'd12; ext_data = 32'hDEAD_BEEF;
    @(negedge clk);
    insn_valid = 1'b0; insn_word = '0; ext_we = 1'b0;
    read_reg(4'd12, rv);
    chk_eq("R11 unit result kept", rv, 32'h1);
    ext_load(4'd13, 32'hCAFE_0042);
    read_reg(4'd13, rv);
    chk_eq("R11 writeback lands", rv, 32'hCAFE_0042);

    done = 1'b1;
    report();
  end
endmodule